// File: doc/BRIEF.md
# Asynchronous SRAM/NOR Bus Timing Engine

This block sits between an internal request port and one external asynchronous memory region, which may hold SRAM, PSRAM or NOR flash. Each accepted request becomes exactly one external read or write cycle. The cycle moves through four programmed phases: address setup, address hold, data and bus turnaround. The engine drives chip enable, output enable, write enable, an address-valid strobe, byte-lane enables, the address lines and a data bus with a separate output enable.

Writes can use a second timing set when extended timing is on. For PSRAM and NOR, the low address bits can share the data bus. A wait input from the memory can lengthen the data phase.

The request side is valid/ready. `req_ready` is high only while the region is enabled and no cycle is in flight, including its turnaround. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The caller may hold `req_valid` high for as long as it likes. The response side cannot apply back-pressure: `rsp_valid` is a single-cycle acknowledge, and for reads it carries the captured data. All configuration inputs are sampled when a request is accepted. They are expected to change only while `cfg_bank_en` is low.

Top module: `extmem_async_ctrl`

## Requirements
- R1: With field values S, H and D for setup, hold and data, and no wait stretching, `mem_ce_n` stays low for exactly (S+1)+(H+1)+(D+1) consecutive cycles. A field value of 0 means one cycle.
- R2: During the data phase, a read drives `mem_oe_n` low and a write drives `mem_we_n` low. Each stays low for the data-phase length. The other strobe stays high for the whole access.
- R3: When `cfg_ext_en`=1, writes take their phase lengths from the `cfg_wr_*` fields and reads from the `cfg_rd_*` fields. When `cfg_ext_en`=0, both reads and writes use the `cfg_rd_*` fields.
- R4: Multiplexing is active only when `cfg_mux_en`=1 and `cfg_mem_type` is PSRAM (2'd1) or NOR (2'd2); SRAM is 2'd0.
  - When multiplexing is active, `mem_dq_oe`=1 and `mem_dq_out` equals the low data-width bits of the address during setup and hold.
  - Otherwise the bus is not driven during those phases.
  - During the data phase a write drives the write data, and a read leaves the bus undriven.
- R5: `mem_adv_n` is low during the whole setup phase, and only then, when multiplexing is active or the memory type is NOR. It stays high for non-multiplexed SRAM and PSRAM.
- R6: When `cfg_wait_en`=1, a high `mem_wait` holds the data phase at its last cycle. The data phase then lasts max(D, W)+1 cycles, where W is the number of data-phase cycles during which wait is seen high from its start. When `cfg_wait_en`=0, `mem_wait` has no effect.
- R7: While `cfg_bank_en`=0, `req_ready` is low and no external cycle starts, even if `req_valid` is held high.
- R8: During an access, `mem_be_n[i]` is low exactly when `req_be[i]` was set and lane i is active. All lanes are active when `cfg_wide`=1. Only lane 0 is active when `cfg_wide`=0. Outside an access all lanes are high.
- R9: Read data is sampled from `mem_dq_in` on the last clock of the data phase. `rsp_valid` is high for exactly one cycle, the first cycle after `mem_ce_n` rises, and for reads `rsp_rdata` holds the sampled data in that cycle.
- R10: After every access, a turnaround of T+1 cycles follows, with `mem_ce_n` high and `req_ready` low. T is the turnaround field of the set in use.
- R11: After reset, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_adv_n` and all `mem_be_n` bits are high, and `mem_dq_oe` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bank_en | input | 1 | Region enable |
| cfg_mem_type | input | 2 | 0 SRAM, 1 PSRAM, 2 NOR |
| cfg_mux_en | input | 1 | Request address/data multiplexing |
| cfg_wait_en | input | 1 | Let mem_wait stretch the data phase |
| cfg_ext_en | input | 1 | Writes use the write timing set |
| cfg_wide | input | 1 | 1: all byte lanes, 0: lane 0 only |
| cfg_rd_setup | input | 4 | Read set: address setup length minus one |
| cfg_rd_hold | input | 4 | Read set: address hold length minus one |
| cfg_rd_data | input | 4 | Read set: data phase length minus one |
| cfg_rd_turn | input | 4 | Read set: turnaround length minus one |
| cfg_wr_setup | input | 4 | Write set: address setup length minus one |
| cfg_wr_hold | input | 4 | Write set: address hold length minus one |
| cfg_wr_data | input | 4 | Write set: data phase length minus one |
| cfg_wr_turn | input | 4 | Write set: turnaround length minus one |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte-lane select |
| rsp_valid | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | DW | Read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_be_n | output | DW/8 | Byte-lane enables, active low |
| mem_addr | output | AW | Address lines |
| mem_dq_out | output | DW | Data bus out |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW | Data bus in |
| mem_wait | input | 1 | Memory wait, high stretches |

## Verification
Access cycles are tried with random phase fields from 0 to 3 across all three memory types, with the multiplex, extended-timing, wide and wait settings each randomised. This separates a wrong phase count from a wrong choice of timing set, and a wrong multiplex decision from a wrong strobe decision. The wait input is driven for a random number of data cycles, both shorter and longer than the programmed data length. Because wait is also toggled while it is disabled, stretching can be told apart from ignoring. Directed cases cover the following:
- a region held disabled under a pending request;
- SRAM with multiplexing requested, which must not multiplex;
- NOR without multiplexing, which must still pulse the address-valid strobe;
- a read bus that shows garbage outside output enable, so that sampling on the wrong clock is caught.

// File: rtl/extmem_pkg.sv
package extmem_pkg;
  parameter int TW = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HOLD,
    PH_DATA,
    PH_TURN
  } phase_e;

  localparam logic [1:0] MT_SRAM  = 2'd0;
  localparam logic [1:0] MT_PSRAM = 2'd1;
  localparam logic [1:0] MT_NOR   = 2'd2;

  typedef struct packed {
    logic [TW-1:0] setup;
    logic [TW-1:0] hold;
    logic [TW-1:0] data;
    logic [TW-1:0] turn;
  } tset_t;
endpackage

// File: rtl/extmem_tsel.sv
module extmem_tsel
  import extmem_pkg::*;
(
  input  logic          ext_en,
  input  logic          is_write,
  input  logic [1:0]    mem_type,
  input  logic          mux_en,
  input  tset_t         rd_set,
  input  tset_t         wr_set,
  output tset_t         sel_set,
  output logic          mux_eff,
  output logic          adv_en
);
  logic use_wr;

  always_comb begin
    use_wr  = ext_en && is_write;
    sel_set = use_wr ? wr_set : rd_set;
    mux_eff = mux_en && ((mem_type == MT_PSRAM) || (mem_type == MT_NOR));
    adv_en  = mux_eff || (mem_type == MT_NOR);
  end
endmodule

// File: rtl/extmem_seq.sv
module extmem_seq
  import extmem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  tset_t  tset,
  input  logic   wait_hold,
  output phase_e phase,
  output logic   last_data
);
  tset_t         tq;
  logic [TW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign last_data = (phase == PH_DATA) && cnt_zero && !wait_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      tq    <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_SETUP;
            cnt   <= tset.setup;
            tq    <= tset;
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase <= PH_HOLD;
            cnt   <= tq.hold;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_zero) begin
            phase <= PH_DATA;
            cnt   <= tq.data;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_DATA: begin
          if (cnt_zero) begin
            if (!wait_hold) begin
              phase <= PH_TURN;
              cnt   <= tq.turn;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_TURN: begin
          if (cnt_zero) phase <= PH_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_setup_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP && cnt_zero) |=> (phase == PH_HOLD));

  p_wait_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && cnt_zero && wait_hold) |=> (phase == PH_DATA));

  p_turn_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN && !cnt_zero) |=> (phase == PH_TURN));
endmodule

// File: rtl/extmem_pins.sv
module extmem_pins
  import extmem_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  localparam int NL = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          c_write,
  input  logic [AW-1:0] c_addr,
  input  logic [DW-1:0] c_wdata,
  input  logic [NL-1:0] c_be,
  input  logic          c_mux,
  input  logic          c_adv,
  input  logic          c_wide,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          adv_n,
  output logic [NL-1:0] be_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  logic in_access;
  logic in_addr_ph;
  logic in_data_ph;

  always_comb begin
    in_addr_ph = (phase == PH_SETUP) || (phase == PH_HOLD);
    in_data_ph = (phase == PH_DATA);
    in_access  = in_addr_ph || in_data_ph;
    ce_n       = !in_access;
    oe_n       = !(in_data_ph && !c_write);
    we_n       = !(in_data_ph && c_write);
    adv_n      = !((phase == PH_SETUP) && c_adv);
    addr       = c_addr;
    dq_oe      = (in_addr_ph && c_mux) || (in_data_ph && c_write);
    dq_out     = in_addr_ph ? c_addr[DW-1:0] : c_wdata;
  end

  for (genvar i = 0; i < NL; i++) begin : g_lane
    if (i == 0) begin : g_base
      assign be_n[i] = !(in_access && c_be[i]);
    end else begin : g_upper
      assign be_n[i] = !(in_access && c_be[i] && c_wide);
    end
  end

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_adv_setup_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> (phase == PH_SETUP));
endmodule

// File: rtl/extmem_async_ctrl.sv
module extmem_async_ctrl
  import extmem_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  localparam int NL = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_bank_en,
  input  logic [1:0]    cfg_mem_type,
  input  logic          cfg_mux_en,
  input  logic          cfg_wait_en,
  input  logic          cfg_ext_en,
  input  logic          cfg_wide,
  input  logic [TW-1:0] cfg_rd_setup,
  input  logic [TW-1:0] cfg_rd_hold,
  input  logic [TW-1:0] cfg_rd_data,
  input  logic [TW-1:0] cfg_rd_turn,
  input  logic [TW-1:0] cfg_wr_setup,
  input  logic [TW-1:0] cfg_wr_hold,
  input  logic [TW-1:0] cfg_wr_data,
  input  logic [TW-1:0] cfg_wr_turn,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NL-1:0] req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_adv_n,
  output logic [NL-1:0] mem_be_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          mem_wait
);
  tset_t   rd_set, wr_set, sel_set;
  logic    sel_mux, sel_adv;
  logic    accept;
  phase_e  phase;
  logic    last_data;

  logic          c_write, c_mux, c_adv, c_wide, c_wait_en;
  logic [1:0]    c_type;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata;
  logic [NL-1:0] c_be;

  assign rd_set = '{setup: cfg_rd_setup, hold: cfg_rd_hold,
                    data:  cfg_rd_data,  turn: cfg_rd_turn};
  assign wr_set = '{setup: cfg_wr_setup, hold: cfg_wr_hold,
                    data:  cfg_wr_data,  turn: cfg_wr_turn};

  extmem_tsel u_tsel (
    .ext_en   (cfg_ext_en),
    .is_write (req_write),
    .mem_type (cfg_mem_type),
    .mux_en   (cfg_mux_en),
    .rd_set   (rd_set),
    .wr_set   (wr_set),
    .sel_set  (sel_set),
    .mux_eff  (sel_mux),
    .adv_en   (sel_adv)
  );

  assign req_ready = cfg_bank_en && (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_write   <= 1'b0;
      c_mux     <= 1'b0;
      c_adv     <= 1'b0;
      c_wide    <= 1'b0;
      c_wait_en <= 1'b0;
      c_type    <= MT_SRAM;
      c_addr    <= '0;
      c_wdata   <= '0;
      c_be      <= '0;
    end else if (accept) begin
      c_write   <= req_write;
      c_mux     <= sel_mux;
      c_adv     <= sel_adv;
      c_wide    <= cfg_wide;
      c_wait_en <= cfg_wait_en;
      c_type    <= cfg_mem_type;
      c_addr    <= req_addr;
      c_wdata   <= req_wdata;
      c_be      <= req_be;
    end
  end

  extmem_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .tset      (sel_set),
    .wait_hold (c_wait_en && mem_wait),
    .phase     (phase),
    .last_data (last_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= last_data;
      if (last_data && !c_write) rsp_rdata <= mem_dq_in;
    end
  end

  extmem_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .c_write (c_write),
    .c_addr  (c_addr),
    .c_wdata (c_wdata),
    .c_be    (c_be),
    .c_mux   (c_mux),
    .c_adv   (c_adv),
    .c_wide  (c_wide),
    .ce_n    (mem_ce_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .adv_n   (mem_adv_n),
    .be_n    (mem_be_n),
    .addr    (mem_addr),
    .dq_out  (mem_dq_out),
    .dq_oe   (mem_dq_oe)
  );

  p_ready_needs_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bank_en |-> !req_ready);

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_sram_plain_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_type == MT_SRAM && (phase == PH_SETUP || phase == PH_HOLD)) |-> !mem_dq_oe);

  p_lanes_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (&mem_be_n));
endmodule

// File: tb/tb_extmem_async_ctrl.sv
module tb_extmem_async_ctrl;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int NL = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cfg_bank_en = 0, cfg_mux_en = 0, cfg_wait_en = 0, cfg_ext_en = 0, cfg_wide = 1;
  logic [1:0]    cfg_mem_type = 0;
  logic [3:0]    rs = 0, rh = 0, rd = 0, rt = 0, ws = 0, wh = 0, wd = 0, wt = 0;
  logic          req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic [NL-1:0] req_be = 0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [NL-1:0] mem_be_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out, mem_dq_in;
  logic          mem_wait;

  int  checks = 0, fails = 0;
  int  dcnt = 0;
  int  wait_len = 0;
  bit  wait_drive = 0;

  function automatic logic [DW-1:0] memval(logic [AW-1:0] a);
    return a[15:0] ^ {a[23:16], 8'hC3};
  endfunction

  assign mem_dq_in = mem_oe_n ? 16'hDEAD : memval(mem_addr);
  assign mem_wait  = wait_drive && (dcnt < wait_len);

  always @(posedge clk) begin
    if (!mem_oe_n || !mem_we_n) dcnt <= dcnt + 1;
    else                        dcnt <= 0;
  end

  extmem_async_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_bank_en(cfg_bank_en), .cfg_mem_type(cfg_mem_type), .cfg_mux_en(cfg_mux_en),
    .cfg_wait_en(cfg_wait_en), .cfg_ext_en(cfg_ext_en), .cfg_wide(cfg_wide),
    .cfg_rd_setup(rs), .cfg_rd_hold(rh), .cfg_rd_data(rd), .cfg_rd_turn(rt),
    .cfg_wr_setup(ws), .cfg_wr_hold(wh), .cfg_wr_data(wd), .cfg_wr_turn(wt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_adv_n(mem_adv_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit mux_exp();
    return cfg_mux_en && (cfg_mem_type == 2'd1 || cfg_mem_type == 2'd2);
  endfunction

  function automatic int dlen_exp(int d);
    if (cfg_wait_en && wait_drive && wait_len > d) return wait_len + 1;
    return d + 1;
  endfunction

  task automatic txn(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [NL-1:0] be);
    int s, h, dd, t, dl, idx, ce, oe, we, adv, turn, rsp_idx, rsp_n;
    bit bus_ok, be_ok, acc;
    logic [DW-1:0] got;
    logic [NL-1:0] exp_ben;
    bit use_wr;
    use_wr = cfg_ext_en && wr;
    s  = use_wr ? int'(ws) : int'(rs);
    h  = use_wr ? int'(wh) : int'(rh);
    dd = use_wr ? int'(wd) : int'(rd);
    t  = use_wr ? int'(wt) : int'(rt);
    dl = dlen_exp(dd);
    exp_ben = ~(be & (cfg_wide ? 2'b11 : 2'b01));
    req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1;
    acc = 0;
    for (int k = 0; k < 50 && !acc; k++) begin
      acc = req_ready;
      @(negedge clk);
    end
    req_valid = 0;
    idx = 0; ce = 0; oe = 0; we = 0; adv = 0; turn = 0; rsp_idx = -1; rsp_n = 0;
    bus_ok = 1; be_ok = 1; got = 0;
    for (int k = 0; k < 200 && !req_ready; k++) begin
      if (!mem_ce_n) begin
        ce++;
        if (mem_be_n != exp_ben) be_ok = 0;
        if (mem_oe_n && mem_we_n) begin
          if (mux_exp()) begin
            if (!mem_dq_oe || mem_dq_out != a[DW-1:0]) bus_ok = 0;
          end else if (mem_dq_oe) bus_ok = 0;
        end else if (!mem_we_n) begin
          if (!mem_dq_oe || mem_dq_out != d) bus_ok = 0;
        end else if (mem_dq_oe) bus_ok = 0;
      end else begin
        turn++;
        if (mem_be_n != 2'b11) be_ok = 0;
      end
      if (!mem_oe_n) oe++;
      if (!mem_we_n) we++;
      if (!mem_adv_n) adv++;
      if (rsp_valid) begin rsp_n++; rsp_idx = idx; got = rsp_rdata; end
      idx++;
      @(negedge clk);
    end
    chk(ce == s + h + dl + 2, use_wr ? "R3" : "R1", "ce low cycles", ce, s + h + dl + 2);
    chk((wr ? we : oe) == dl, "R2", "strobe length", wr ? we : oe, dl);
    chk((wr ? oe : we) == 0, "R2", "wrong strobe", wr ? oe : we, 0);
    chk(adv == ((mux_exp() || cfg_mem_type == 2'd2) ? s + 1 : 0), "R5", "adv cycles", adv,
        (mux_exp() || cfg_mem_type == 2'd2) ? s + 1 : 0);
    chk(bus_ok, "R4", "bus drive pattern", bus_ok, 1);
    chk(be_ok, "R8", "byte lanes", be_ok, 1);
    chk(rsp_n == 1 && rsp_idx == ce, "R9", "rsp position", rsp_idx, ce);
    if (!wr) chk(got == memval(a), "R9", "read data", got, memval(a));
    chk(turn == t + 1, "R10", "turnaround", turn, t + 1);
  endtask

  task automatic set_cfg(logic [1:0] ty, bit mx, bit wn, bit ex, bit wide);
    cfg_bank_en = 0;
    @(negedge clk);
    cfg_mem_type = ty; cfg_mux_en = mx; cfg_wait_en = wn; cfg_ext_en = ex; cfg_wide = wide;
    @(negedge clk);
    cfg_bank_en = 1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_adv_n && mem_be_n == 2'b11 && !mem_dq_oe && !rsp_valid,
        "R11", "reset state", 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce_n && !rsp_valid, "R11", "idle after reset", mem_ce_n, 1);

    // R7: disabled region ignores a held request
    req_valid = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k == 9) chk(!req_ready && mem_ce_n, "R7", "disabled start", req_ready, 0);
    end
    req_valid = 0;

    // directed: SRAM with mux requested stays plain (R4), rd set used
    rs = 1; rh = 0; rd = 2; rt = 1; ws = 3; wh = 2; wd = 0; wt = 2;
    set_cfg(2'd0, 1, 0, 0, 1);
    txn(0, 24'h12A5F0, 16'h0, 2'b11);
    txn(1, 24'h0033CC, 16'hBEEF, 2'b10);
    // directed: NOR without mux still pulses adv (R5), ext set for writes (R3)
    set_cfg(2'd2, 0, 0, 1, 0);
    txn(1, 24'h00F00F, 16'h1234, 2'b11);
    txn(0, 24'h00F010, 16'h0, 2'b01);
    // directed: wait driven but disabled (R6 ignore), then enabled
    wait_drive = 1; wait_len = 6;
    set_cfg(2'd1, 1, 0, 0, 1);
    txn(0, 24'h777777, 16'h0, 2'b11);
    set_cfg(2'd1, 1, 1, 0, 1);
    txn(0, 24'h777778, 16'h0, 2'b11);
    txn(1, 24'h777779, 16'hA5A5, 2'b11);

    // random mix
    for (int n = 0; n < 80; n++) begin
      rs = 4'($urandom_range(0, 3)); rh = 4'($urandom_range(0, 3));
      rd = 4'($urandom_range(0, 3)); rt = 4'($urandom_range(0, 3));
      ws = 4'($urandom_range(0, 3)); wh = 4'($urandom_range(0, 3));
      wd = 4'($urandom_range(0, 3)); wt = 4'($urandom_range(0, 3));
      wait_drive = 1'($urandom_range(0, 1));
      wait_len = $urandom_range(0, 6);
      set_cfg(2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      txn(1'($urandom_range(0, 1)), AW'($urandom), DW'($urandom), NL'($urandom_range(0, 3)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule